// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block selects one of sixteen lines from a 4-bit code. The code first passes through a hold stage that behaves like a level-sensitive latch. While the strobe is high, the code on the inputs goes straight to the decoder. While the strobe is low, the decoder sees the code that was held last. The hold stage is built as a clocked equivalent. At every rising clock edge where the strobe is high, it records the input code. When the strobe is low, it keeps its contents.

An inhibit input drives every select line to its inactive level at once. It does not touch the held code, so the decode comes back as soon as inhibit is released. The polarity of the select lines is fixed when the block is built, through a parameter: active-high (one line at 1) or active-low (one line at 0).

All inputs are plain control pins with no handshake. The outputs are combinational from the strobe, the code, the inhibit and the held code.

Top module: `latched_decoder`

## Requirements
- R1: While `strobe_i` is 1, `sel_o` decodes the present value of `code_i` in the same cycle, with no clock edge in between.
- R2: While `strobe_i` is 0, `sel_o` decodes the held code. The held code is the `code_i` value sampled at the last rising edge of `clk_i` at which `strobe_i` was 1. Changes on `code_i` while `strobe_i` is 0 have no effect.
- R3: Bit 0 of `code_i` is the least significant bit and bit 3 is the most significant. Code value n selects `sel_o[n]`, for n from 0 to 15.
- R4: With `POL = POL_HIGH`, the selected line is 1 and the other fifteen lines are 0.
- R5: With `POL = POL_LOW`, the selected line is 0 and the other fifteen lines are 1.
- R6: While `inhibit_i` is 1, every line of `sel_o` is at its inactive level (all 0 for `POL_HIGH`, all 1 for `POL_LOW`), whatever the values of `code_i` and `strobe_i`.
- R7: Inhibit leaves the held code unchanged. Once `inhibit_i` returns to 0 with `strobe_i` low, `sel_o` decodes the code held before inhibit was raised.
- R8: While `rst_ni` is 0, and after it until the first capture, the held code is 0.
- R9: While `inhibit_i` is 0, exactly one line of `sel_o` is at its active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock that samples the strobe and the code |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the held code to 0 |
| strobe_i | input | 1 | 1: the hold stage is transparent; 0: the held code is kept |
| code_i | input | 4 | Code to decode; bit 0 is the least significant bit |
| inhibit_i | input | 1 | 1: all select lines go inactive |
| sel_o | output | 16 | Select lines; the polarity is set by `POL` |

## Verification
The select lines are combinational, so a result that depends on the strobe, the code or the inhibit is due in the same cycle as the stimulus. A capture into the hold stage takes effect at the next rising edge. The bench drives inputs on the falling edge and samples 1 ns later. It keeps its own model of the held code, which it updates at each rising edge where the strobe was high. Every sample is therefore compared against the state the design should hold at that moment. Both polarity builds run side by side on the same stimulus: directed hold, inhibit and reset cases, and a long seeded random stretch.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic {POL_HIGH = 1'b0, POL_LOW = 1'b1} polarity_e;
endpackage

// File: rtl/code_hold.sv
module code_hold #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       held_q <= '0;
    else if (strobe_i) held_q <= code_i;
  end

  // transparent while strobe is high, otherwise the stored code
  assign code_o = strobe_i ? code_i : held_q;

  // R2
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(held_q));
  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> held_q == $past(code_i));
endmodule

// File: rtl/code_decode.sv
module code_decode #(
  parameter int CODE_W = 4,
  localparam int OUT_N = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [OUT_N-1:0]  hot_o
);
  for (genvar n = 0; n < OUT_N; n++) begin : g_line
    assign hot_o[n] = (code_i == CODE_W'(n));
  end
endmodule

// File: rtl/out_drive.sv
module out_drive #(
  parameter int                  OUT_N = 16,
  parameter dec_pkg::polarity_e  POL   = dec_pkg::POL_HIGH
) (
  input  logic             inhibit_i,
  input  logic [OUT_N-1:0] hot_i,
  output logic [OUT_N-1:0] sel_o
);
  if (POL == dec_pkg::POL_LOW) begin : g_low
    assign sel_o = inhibit_i ? {OUT_N{1'b1}} : ~hot_i;
  end else begin : g_high
    assign sel_o = inhibit_i ? {OUT_N{1'b0}} : hot_i;
  end
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int                 CODE_W = 4,
  parameter dec_pkg::polarity_e POL    = dec_pkg::POL_HIGH,
  localparam int                OUT_N  = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              inhibit_i,
  output logic [OUT_N-1:0]  sel_o
);
  logic [CODE_W-1:0] eff_code;
  logic [OUT_N-1:0]  hot;

  code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .code_i(code_i), .code_o(eff_code));

  code_decode #(.CODE_W(CODE_W)) u_dec (.code_i(eff_code), .hot_o(hot));

  out_drive #(.OUT_N(OUT_N), .POL(POL)) u_drv (
    .inhibit_i(inhibit_i), .hot_i(hot), .sel_o(sel_o));

  // select lines seen as active-high, whichever build this is
  logic [OUT_N-1:0] act_view;
  assign act_view = (POL == dec_pkg::POL_LOW) ? ~sel_o : sel_o;

  // R6
  inhibit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> act_view == '0);
  // R9
  one_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_i |-> $countones(act_view) == 1);
  // R1
  transparent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !inhibit_i) |-> act_view[code_i]);
  // R2
  held_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !inhibit_i && $past(strobe_i) && !$past(inhibit_i)) |->
      act_view == $past(act_view));
endmodule

// File: tb/test_latched_decoder.sv
module test_latched_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [3:0] code = 4'd0;
  logic inhibit = 1'b0;
  logic [15:0] sel_hi, sel_lo;
  logic [3:0] m_held;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  latched_decoder #(.POL(dec_pkg::POL_HIGH)) i_latched_decoder (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .code_i(code),
    .inhibit_i(inhibit), .sel_o(sel_hi));
  latched_decoder #(.POL(dec_pkg::POL_LOW)) i_latched_decoder_low (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .code_i(code),
    .inhibit_i(inhibit), .sel_o(sel_lo));

  // bench model of the held code (R2, R8)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_held <= 4'd0;
    else if (strobe) m_held <= code;

  function automatic logic [15:0] exp_sel(logic [3:0] c, logic inh, logic low);
    logic [15:0] h;
    h = inh ? 16'h0000 : (16'h0001 << c);
    return low ? ~h : h;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_both(string req);
    logic [3:0] c;
    c = strobe ? code : m_held;
    chk({req, " high"}, sel_hi, exp_sel(c, inhibit, 1'b0));
    chk({req, " low"},  sel_lo, exp_sel(c, inhibit, 1'b1));
  endtask

  task automatic step(logic s, logic [3:0] d, logic ih, string req);
    @(negedge clk);
    strobe = s; code = d; inhibit = ih;
    #1;
    check_both(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED);
    // R8: held code 0 under reset and after it, strobe low
    code = 4'd11;
    #7;
    chk("R8 reset high", sel_hi, 16'h0001);
    chk("R8 reset low",  sel_lo, 16'hFFFE);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 4'd7, 1'b0, "R8 after reset");
    // R1 R3 R4 R5 R9: every code, transparent
    for (int n = 0; n < 16; n++) begin
      step(1'b1, 4'(n), 1'b0, "R3");
      chk("R4 line", {15'd0, sel_hi[n]}, 16'd1);
      chk("R5 line", {15'd0, sel_lo[n]}, 16'd0);
    end
    // R1: code change visible in same cycle while strobe high
    step(1'b1, 4'd5, 1'b0, "R1");
    // R2: fall of strobe keeps 5, later changes ignored
    step(1'b0, 4'd5, 1'b0, "R2 fall");
    step(1'b0, 4'd9, 1'b0, "R2 ignore");
    chk("R2 held5", sel_hi, 16'h0020);
    step(1'b0, 4'd14, 1'b0, "R2 ignore");
    // R6: inhibit with strobe high and low
    step(1'b0, 4'd3, 1'b1, "R6 strobe0");
    chk("R6 idle high", sel_hi, 16'h0000);
    chk("R6 idle low",  sel_lo, 16'hFFFF);
    // R7: release inhibit, held code 5 back
    step(1'b0, 4'd3, 1'b0, "R7");
    chk("R7 held5", sel_hi, 16'h0020);
    step(1'b1, 4'd12, 1'b1, "R6 strobe1");
    step(1'b0, 4'd0, 1'b0, "R7 capture under inhibit");
    chk("R7 held12", sel_lo, 16'hEFFF);
    // random stretch: R1 R2 R6 R9
    for (int k = 0; k < 3000; k++) begin
      logic s, ih;
      logic [3:0] d;
      s  = ($urandom % 3) == 0;
      ih = ($urandom % 8) == 0;
      d  = 4'($urandom);
      step(s, d, ih, "R1/R2/R6/R9 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule